// File: doc/BRIEF.md
# Cascaded Set/Clear Interrupt Controller

This block gathers up to sixteen external interrupt inputs into one active-low, level-sensitive request line for a host processor. Each source has three per-bit state bits: enable, mask and pending. A source latches its pending bit on a rising edge of its input, but only while its enable bit is 1. The host request is driven low while any source is pending, enabled and unmasked at the same time.

Software reaches the state through a small 16-bit register port. Enable and mask can only be changed through dedicated set and clear addresses. Pending bits are acknowledged by writing ones to the status address. No register ever needs a read-modify-write, so several software agents can share the block without locking. A separate read-only address returns the raw, unlatched level of every source input, and software services pending sources from the lowest set bit upward.

Top module: `irq_cascade_ctrl`

## Requirements
- R1: After reset, enable, mask and pending are all zero and `irq_n_o` is 1.
- R2: A write to address 1 sets each enable bit whose data bit is 1. A write to address 2 clears each enable bit whose data bit is 1. Data bits that are 0 leave the enable bits unchanged. Reading address 1 or 2 returns the enable register.
- R3: Addresses 3 (set) and 4 (clear) change the mask register with the same write-one rules. Reading address 3 or 4 returns the mask register.
- R4: A pending bit is set one clock edge after a 0-to-1 change of its source, but only if that source's enable bit is 1 at that edge. A source that stays high, or that rises while disabled, sets nothing.
- R5: Writing to address 0 clears each pending bit whose data bit is 1 and leaves the other pending bits unchanged. Reading address 0 returns the pending vector, with bit n belonging to source n.
- R6: If a source edge that would set a pending bit arrives in the same cycle as a status write clearing that bit, the bit ends up set.
- R7: `irq_n_o` is 0 exactly when some bit is 1 in pending, enable and mask at once.
- R8: Reading address 5 returns the current raw source levels. Reading addresses 6 to 15 returns zero.
- R9: Writing 0xFFFF to addresses 2, 4 and 0 leaves every source disabled, masked and not pending, with `irq_n_o` at 1.
- R10: Writes to addresses 5 to 15 change no enable, mask or pending bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | NSRC | Interrupt source levels |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register address |
| reg_wdata_i | input | NSRC | Register write data |
| reg_rdata_o | output | NSRC | Register read data (combinational on address) |
| irq_n_o | output | 1 | Combined active-low interrupt request |

## Verification
The bench sends a source rising edge in the same cycle as an acknowledge of that bit. A design that gave priority to the clear would lose that interrupt. The bench holds sources high across enable changes and raises sources while they are disabled. An edge detector that is really level-triggered, or a latch that ignores enable, would show pending bits that should not be there. The bench writes patterns that are mostly zero to the set and clear addresses, and writes to read-only addresses. This catches designs that overwrite the whole register or decode the address loosely. Finally, it clears the mask or enable bit under a pending source to show that the request line depends on all three registers.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    localparam int ADDR_W = 4;

    typedef enum logic [ADDR_W-1:0] {
        A_PEND    = 4'd0,
        A_EN_SET  = 4'd1,
        A_EN_CLR  = 4'd2,
        A_MSK_SET = 4'd3,
        A_MSK_CLR = 4'd4,
        A_RAW     = 4'd5
    } reg_addr_e;
endpackage

// File: rtl/irqc_edge.sv
module irqc_edge #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl_i,
    output logic [W-1:0] rise_o
);
    logic [W-1:0] prev_d, prev_q;

    for (genvar g = 0; g < W; g++) begin : g_bit
        always_comb begin
            prev_d[g] = lvl_i[g];
            rise_o[g] = lvl_i[g] & ~prev_q[g];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) prev_q[g] <= 1'b0;
            else        prev_q[g] <= prev_d[g];
        end
    end
endmodule

// File: rtl/irqc_regs.sv
module irqc_regs
    import irqc_pkg::*;
#(
    parameter int W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [W-1:0]      wdata_i,
    input  logic [W-1:0]      rise_i,
    input  logic [W-1:0]      raw_i,
    output logic [W-1:0]      en_o,
    output logic [W-1:0]      mask_o,
    output logic [W-1:0]      pend_o,
    output logic [W-1:0]      rdata_o
);
    typedef struct packed {
        logic [W-1:0] en;
        logic [W-1:0] mask;
        logic [W-1:0] pend;
    } state_t;

    state_t st_d, st_q;
    logic [W-1:0] en_set, en_clr, msk_set, msk_clr, pend_clr, latch_set;

    always_comb begin
        en_set    = (wr_i && addr_i == A_EN_SET)  ? wdata_i : '0;
        en_clr    = (wr_i && addr_i == A_EN_CLR)  ? wdata_i : '0;
        msk_set   = (wr_i && addr_i == A_MSK_SET) ? wdata_i : '0;
        msk_clr   = (wr_i && addr_i == A_MSK_CLR) ? wdata_i : '0;
        pend_clr  = (wr_i && addr_i == A_PEND)    ? wdata_i : '0;
        latch_set = rise_i & st_q.en;

        st_d      = st_q;
        st_d.en   = (st_q.en   | en_set)  & ~en_clr;
        st_d.mask = (st_q.mask | msk_set) & ~msk_clr;
        // a fresh edge outranks an acknowledge of the same bit
        st_d.pend = (st_q.pend & ~pend_clr) | latch_set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        case (addr_i)
            A_PEND:               rdata_o = st_q.pend;
            A_EN_SET, A_EN_CLR:   rdata_o = st_q.en;
            A_MSK_SET, A_MSK_CLR: rdata_o = st_q.mask;
            A_RAW:                rdata_o = raw_i;
            default:              rdata_o = '0;
        endcase
    end

    assign en_o   = st_q.en;
    assign mask_o = st_q.mask;
    assign pend_o = st_q.pend;

    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (en_o == '0 && mask_o == '0 && pend_o == '0));

    assert_en_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && addr_i == A_EN_SET) |=> ((en_o & $past(wdata_i)) == $past(wdata_i)));

    assert_en_clr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && addr_i == A_EN_CLR) |=> ((en_o & $past(wdata_i)) == '0));

    assert_msk_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && addr_i == A_MSK_SET) |=> ((mask_o & $past(wdata_i)) == $past(wdata_i)));

    assert_msk_clr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && addr_i == A_MSK_CLR) |=> ((mask_o & $past(wdata_i)) == '0));

    assert_pend_needs_en_R4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend_o & ~$past(pend_o) & ~$past(en_o)) == '0));

    assert_pend_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && addr_i == A_PEND)
        |=> ((pend_o & $past(wdata_i & ~(rise_i & en_o))) == '0));

    assert_set_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (|(rise_i & en_o))
        |=> ((pend_o & $past(rise_i & en_o)) == $past(rise_i & en_o)));

    assert_ro_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && addr_i >= A_RAW)
        |=> ($stable(en_o) && $stable(mask_o)));
endmodule

// File: rtl/irqc_merge.sv
module irqc_merge #(
    parameter int W = 16
) (
    input  logic [W-1:0] en_i,
    input  logic [W-1:0] mask_i,
    input  logic [W-1:0] pend_i,
    output logic         irq_n_o
);
    logic [W-1:0] live;

    always_comb begin
        live    = pend_i & en_i & mask_i;
        irq_n_o = ~(|live);
    end
endmodule

// File: rtl/irq_cascade_ctrl.sv
module irq_cascade_ctrl
    import irqc_pkg::*;
#(
    parameter int NSRC = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   src_i,
    input  logic              reg_wr_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [NSRC-1:0]   reg_wdata_i,
    output logic [NSRC-1:0]   reg_rdata_o,
    output logic              irq_n_o
);
    logic [NSRC-1:0] rise_w, en_w, mask_w, pend_w;

    irqc_edge #(.W(NSRC)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  (src_i),
        .rise_o (rise_w)
    );

    irqc_regs #(.W(NSRC)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (reg_wr_i),
        .addr_i  (reg_addr_i),
        .wdata_i (reg_wdata_i),
        .rise_i  (rise_w),
        .raw_i   (src_i),
        .en_o    (en_w),
        .mask_o  (mask_w),
        .pend_o  (pend_w),
        .rdata_o (reg_rdata_o)
    );

    irqc_merge #(.W(NSRC)) u_merge (
        .en_i    (en_w),
        .mask_i  (mask_w),
        .pend_i  (pend_w),
        .irq_n_o (irq_n_o)
    );

    assert_idle_line_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_w == '0 || en_w == '0 || mask_w == '0) |-> irq_n_o);

    assert_low_needs_pend_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_n_o |-> (pend_w != '0));
endmodule

// File: tb/irq_cascade_ctrl_bench.sv
module irq_cascade_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] src = '0;
    logic        wr = 1'b0;
    logic [3:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        irq_n;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    irq_cascade_ctrl #(.NSRC(16)) u_irq_cascade_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .src_i       (src),
        .reg_wr_i    (wr),
        .reg_addr_i  (addr),
        .reg_wdata_i (wdata),
        .reg_rdata_o (rdata),
        .irq_n_o     (irq_n)
    );

    // fields: wr[85] addr[84:81] wdata[80:65] src[64:49] en[48:33] mask[32:17] pend[16:1] irq_n[0]
    localparam logic [85:0] VEC [12] = '{
        {1'b1, 4'd1, 16'h00FF, 16'h0000, 16'h00FF, 16'h0000, 16'h0000, 1'b1},
        {1'b0, 4'd0, 16'h0000, 16'h0101, 16'h00FF, 16'h0000, 16'h0001, 1'b1},
        {1'b1, 4'd3, 16'h000F, 16'h0101, 16'h00FF, 16'h000F, 16'h0001, 1'b0},
        {1'b0, 4'd0, 16'h0000, 16'h0103, 16'h00FF, 16'h000F, 16'h0003, 1'b0},
        {1'b1, 4'd2, 16'h0001, 16'h0103, 16'h00FE, 16'h000F, 16'h0003, 1'b0},
        {1'b1, 4'd0, 16'h0002, 16'h0103, 16'h00FE, 16'h000F, 16'h0001, 1'b1},
        {1'b1, 4'd1, 16'h0001, 16'h0103, 16'h00FF, 16'h000F, 16'h0001, 1'b0},
        {1'b1, 4'd4, 16'h0001, 16'h0103, 16'h00FF, 16'h000E, 16'h0001, 1'b1},
        {1'b1, 4'd0, 16'h0001, 16'h0000, 16'h00FF, 16'h000E, 16'h0000, 1'b1},
        {1'b0, 4'd0, 16'h0000, 16'h0010, 16'h00FF, 16'h000E, 16'h0010, 1'b1},
        {1'b1, 4'd3, 16'h0010, 16'h0010, 16'h00FF, 16'h001E, 16'h0010, 1'b0},
        {1'b1, 4'd5, 16'hFFFF, 16'h0010, 16'h00FF, 16'h001E, 16'h0010, 1'b0}
    };

    function automatic string vtag(int i);
        case (i)
            0, 4, 6: return "R2";
            1, 3, 9: return "R4";
            2, 7:    return "R3";
            5, 8:    return "R5";
            10:      return "R7";
            default: return "R10";
        endcase
    endfunction

    task automatic chk(string tag, string what, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic step(logic [15:0] s, logic w, logic [3:0] a, logic [15:0] d);
        @(negedge clk);
        src = s; wr = w; addr = a; wdata = d;
        @(posedge clk);
        #1;
        wr = 1'b0;
    endtask

    task automatic rd(logic [3:0] a, output logic [15:0] v);
        addr = a;
        #1;
        v = rdata;
    endtask

    task automatic expect_state(string tag, logic [15:0] e_en, logic [15:0] e_m,
                                logic [15:0] e_p, logic e_irq);
        logic [15:0] v;
        rd(4'd1, v); chk(tag, "enable", v, e_en);
        rd(4'd3, v); chk(tag, "mask", v, e_m);
        rd(4'd0, v); chk(tag, "pending", v, e_p);
        chk(tag, "irq_n", {15'd0, irq_n}, {15'd0, e_irq});
    endtask

    initial begin
        for (int c = 0; c < 100000; c++) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        expect_state("R1", 16'h0000, 16'h0000, 16'h0000, 1'b1);

        for (int i = 0; i < 12; i++) begin
            step(VEC[i][64:49], VEC[i][85], VEC[i][84:81], VEC[i][80:65]);
            expect_state(vtag(i), VEC[i][48:33], VEC[i][32:17], VEC[i][16:1], VEC[i][0]);
        end

        // R4: bit 8 rises while disabled, then is enabled while held high
        step(16'h0110, 1'b0, 4'd0, 16'h0000);
        rd(4'd0, v); chk("R4", "disabled edge", v, 16'h0010);
        step(16'h0110, 1'b1, 4'd1, 16'h0100);
        step(16'h0110, 1'b0, 4'd0, 16'h0000);
        rd(4'd0, v); chk("R4", "held level", v, 16'h0010);

        // R8: raw level readback and unused address
        step(16'hA5C3, 1'b0, 4'd0, 16'h0000);
        rd(4'd5, v); chk("R8", "raw", v, 16'hA5C3);
        rd(4'd9, v); chk("R8", "unused addr", v, 16'h0000);
        rd(4'd0, v); chk("R4", "multi edge", v, 16'h00D3);

        // R6: edge on bit 2 together with a full acknowledge
        step(16'h0000, 1'b0, 4'd0, 16'h0000);
        step(16'h0004, 1'b1, 4'd0, 16'hFFFF);
        rd(4'd0, v); chk("R6", "set wins", v, 16'h0004);

        // R1: reset from a busy state
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        #1;
        expect_state("R1", 16'h0000, 16'h0000, 16'h0000, 1'b1);

        // R9: fill everything, then the three full-clear writes
        step(16'h0004, 1'b1, 4'd1, 16'hFFFF);
        step(16'h0004, 1'b1, 4'd3, 16'hFFFF);
        step(16'h000C, 1'b0, 4'd0, 16'h0000);
        expect_state("R7", 16'hFFFF, 16'hFFFF, 16'h0008, 1'b0);
        step(16'h000C, 1'b1, 4'd2, 16'hFFFF);
        step(16'h000C, 1'b1, 4'd4, 16'hFFFF);
        step(16'h000C, 1'b1, 4'd0, 16'hFFFF);
        expect_state("R9", 16'h0000, 16'h0000, 16'h0000, 1'b1);
        step(16'h001C, 1'b0, 4'd0, 16'h0000);
        rd(4'd0, v); chk("R9", "edge after clear", v, 16'h0000);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule